// File: doc/BRIEF.md
# Conditional Branch and Skip Evaluator

This block settles the control-flow outcome of one conditional instruction. It checks either a status flag (for relative branches) or an external condition (for skips), and returns three things: whether the instruction is taken, the program counter of the next instruction to execute, and how many cycles the instruction costs. Fetch and decode sit outside the block. The decoder supplies the flag index, the polarity, the signed offset, the equality or bit result, and a hint saying whether the instruction after a skip occupies two words.

The status byte is laid out with bit 7 as I, then T, H, S, V, N, Z, and bit 0 as C. A single test, "flag at index equals polarity", covers every named branch alias. For example, same-or-higher and carry-clear are both index 0 with polarity 0. Index 4 is special: it is not read from the stored byte. It is recomputed as N xor V, so signed greater-or-equal and less-than always follow the live N and V bits. Each request raises `evalValid` for one clock, and the result is registered and shown on the following clock.

Top module: `brskip_eval`

## Requirements
- R1: While reset is held, `resValid` is 0, `taken` is 0, `nextPc` is 0 and `cycles` is 0.
- R2: A request with `evalValid`=1 gives a result one clock later, with `resValid`=1 for exactly that clock. When `evalValid`=0, `resValid` is 0 on the next clock and `nextPc`, `taken` and `cycles` keep their values.
- R3: When `opMode`=2'b00 (branch) and `flagIdx` is not 4, the branch is taken exactly when `statusReg[flagIdx]` equals `testSet`. Bit order is C=0, Z=1, N=2, V=3, S=4, H=5, T=6, I=7.
- R4: When `opMode`=2'b00 and `flagIdx`=4, the tested value is `statusReg[2]` xor `statusReg[3]`. The stored bit 4 has no effect.
- R5: A taken branch gives `nextPc` = `curPc` + 1 + sign-extended 7-bit `offset`, modulo 2^PC_W, and `cycles`=2.
- R6: Any request that is not taken gives `nextPc` = `curPc` + 1 (modulo 2^PC_W) and `cycles`=1.
- R7: When `opMode`=2'b01 (skip on equal), the skip is taken exactly when `regEqual`=1. The status byte, flag index and polarity have no effect.
- R8: When `opMode`=2'b10 (skip on bit), the skip is taken exactly when `testedBit` equals `testSet`. `testSet`=1 means skip if the bit is set, and 0 means skip if it is clear.
- R9: A taken skip adds 2 to `curPc` with `cycles`=2 when `nextIsTwoWord`=0. It adds 3 with `cycles`=3 when `nextIsTwoWord`=1. Both additions wrap modulo 2^PC_W.
- R10: When `opMode`=2'b11 (sequential), the request is never taken.
- R11: `offset` has no effect on skip results, and `nextIsTwoWord` has no effect on branch results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| evalValid | input | 1 | Request strobe for one evaluation |
| opMode | input | 2 | 00 branch, 01 skip on equal, 10 skip on bit, 11 sequential |
| statusReg | input | 8 | Status flags, I at bit 7 down to C at bit 0 |
| flagIdx | input | 3 | Flag tested by a branch |
| testSet | input | 1 | Polarity: 1 means act when the condition bit is set |
| offset | input | OFF_W | Signed branch displacement |
| curPc | input | PC_W | Address of the conditional instruction |
| regEqual | input | 1 | Register-compare result for skip on equal |
| testedBit | input | 1 | Register or I/O bit for skip on bit |
| nextIsTwoWord | input | 1 | Following instruction is two words long |
| resValid | output | 1 | Result strobe |
| nextPc | output | PC_W | Next program counter |
| taken | output | 1 | Branch or skip taken |
| cycles | output | 2 | Cycle cost, 1 to 3 |

## Verification
The block keeps no state between requests apart from its output registers. A wrong flag select or a wrong strobe from the control therefore shows up on `taken`, `nextPc` or `cycles` on the clock right after the faulty request. A flag that is mismapped stays hidden until a request tests that index with a status byte in which that bit alone differs. The bench therefore walks every index with single-bit and inverted-bit patterns. It also covers offsets and addresses at the wrap boundaries, where a wrong width or a missing sign extension shows up as a wrong `nextPc`.

// File: rtl/brskip_pkg.sv
package brskip_pkg;

  localparam int SR_W = 8;
  localparam int IDX_W = 3;
  localparam int CYC_W = 2;

  // status byte positions the condition logic depends on
  localparam int FLAG_NEG = 2;
  localparam int FLAG_OVF = 3;
  localparam int FLAG_SIGN = 4;

  typedef enum logic [1:0] {
    MODE_BRANCH  = 2'b00,
    MODE_SKIP_EQ = 2'b01,
    MODE_SKIP_BIT = 2'b10,
    MODE_SEQ     = 2'b11
  } evalMode_t;

  localparam logic [CYC_W-1:0] CYC_ONE   = 2'd1;
  localparam logic [CYC_W-1:0] CYC_TWO   = 2'd2;
  localparam logic [CYC_W-1:0] CYC_THREE = 2'd3;

  // strobes from control to datapath
  typedef struct packed {
    logic fire;       // capture a result this clock
    logic take;       // condition met
    logic useOffset;  // taken target is the relative branch target
    logic longSkip;   // taken skip jumps over a two-word instruction
  } ctlStrobe_t;

endpackage

// File: rtl/brskip_ctrl.sv
module brskip_ctrl
  import brskip_pkg::*;
(
  input  logic             evalValid,
  input  logic [1:0]       opMode,
  input  logic [SR_W-1:0]  statusReg,
  input  logic [IDX_W-1:0] flagIdx,
  input  logic             testSet,
  input  logic             regEqual,
  input  logic             testedBit,
  input  logic             nextIsTwoWord,
  output ctlStrobe_t       strobe
);

  // per-index view of the flags; the sign slot is rebuilt from N and V
  logic [SR_W-1:0] flagView;

  genvar gi;
  generate
    for (gi = 0; gi < SR_W; gi++) begin : gFlag
      if (gi == FLAG_SIGN) begin : gSign
        assign flagView[gi] = statusReg[FLAG_NEG] ^ statusReg[FLAG_OVF];
      end else begin : gRaw
        assign flagView[gi] = statusReg[gi];
      end
    end
  endgenerate

  evalMode_t modeSel;
  logic      flagBit;
  logic      condMet;

  always_comb begin
    modeSel = evalMode_t'(opMode);
    flagBit = flagView[flagIdx];
    unique case (modeSel)
      MODE_BRANCH:   condMet = (flagBit == testSet);
      MODE_SKIP_EQ:  condMet = regEqual;
      MODE_SKIP_BIT: condMet = (testedBit == testSet);
      default:       condMet = 1'b0;
    endcase
  end

  always_comb begin
    strobe.fire      = evalValid;
    strobe.take      = condMet;
    strobe.useOffset = (modeSel == MODE_BRANCH);
    strobe.longSkip  = (modeSel != MODE_BRANCH) && nextIsTwoWord;
  end

endmodule

// File: rtl/brskip_dpath.sv
module brskip_dpath
  import brskip_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int OFF_W = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       strobe,
  input  logic [PC_W-1:0]  curPc,
  input  logic [OFF_W-1:0] offset,
  output logic             resValid,
  output logic [PC_W-1:0]  nextPc,
  output logic             taken,
  output logic [CYC_W-1:0] cycles
);

  localparam int EXT_W = PC_W - OFF_W;
  localparam logic [PC_W-1:0] STEP_ONE   = PC_W'(1);
  localparam logic [PC_W-1:0] STEP_TWO   = PC_W'(2);
  localparam logic [PC_W-1:0] STEP_THREE = PC_W'(3);

  logic [PC_W-1:0]  offExt;
  logic [PC_W-1:0]  seqPc;
  logic [PC_W-1:0]  branchPc;
  logic [PC_W-1:0]  skipPc;
  logic [PC_W-1:0]  pcSel;
  logic [CYC_W-1:0] cycSel;

  assign offExt   = {{EXT_W{offset[OFF_W-1]}}, offset};
  assign seqPc    = curPc + STEP_ONE;
  assign branchPc = seqPc + offExt;
  assign skipPc   = curPc + (strobe.longSkip ? STEP_THREE : STEP_TWO);

  always_comb begin
    if (!strobe.take) begin
      pcSel  = seqPc;
      cycSel = CYC_ONE;
    end else if (strobe.useOffset) begin
      pcSel  = branchPc;
      cycSel = CYC_TWO;
    end else begin
      pcSel  = skipPc;
      cycSel = strobe.longSkip ? CYC_THREE : CYC_TWO;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resValid <= 1'b0;
      nextPc   <= '0;
      taken    <= 1'b0;
      cycles   <= '0;
    end else begin
      resValid <= strobe.fire;
      if (strobe.fire) begin
        nextPc <= pcSel;
        taken  <= strobe.take;
        cycles <= cycSel;
      end
    end
  end

endmodule

// File: rtl/brskip_eval.sv
module brskip_eval
  import brskip_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int OFF_W = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             evalValid,
  input  logic [1:0]       opMode,
  input  logic [7:0]       statusReg,
  input  logic [2:0]       flagIdx,
  input  logic             testSet,
  input  logic [OFF_W-1:0] offset,
  input  logic [PC_W-1:0]  curPc,
  input  logic             regEqual,
  input  logic             testedBit,
  input  logic             nextIsTwoWord,
  output logic             resValid,
  output logic [PC_W-1:0]  nextPc,
  output logic             taken,
  output logic [1:0]       cycles
);

  ctlStrobe_t strobe;

  brskip_ctrl uCtrl (
    .evalValid     (evalValid),
    .opMode        (opMode),
    .statusReg     (statusReg),
    .flagIdx       (flagIdx),
    .testSet       (testSet),
    .regEqual      (regEqual),
    .testedBit     (testedBit),
    .nextIsTwoWord (nextIsTwoWord),
    .strobe        (strobe)
  );

  brskip_dpath #(.PC_W(PC_W), .OFF_W(OFF_W)) uDpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .curPc    (curPc),
    .offset   (offset),
    .resValid (resValid),
    .nextPc   (nextPc),
    .taken    (taken),
    .cycles   (cycles)
  );

endmodule

// File: rtl/brskip_chk.sv
module brskip_chk #(
  parameter int PC_W  = 16,
  parameter int OFF_W = 7
) (
  input logic             clk,
  input logic             rstN,
  input logic             evalValid,
  input logic [1:0]       opMode,
  input logic [7:0]       statusReg,
  input logic [2:0]       flagIdx,
  input logic             testSet,
  input logic [OFF_W-1:0] offset,
  input logic [PC_W-1:0]  curPc,
  input logic             regEqual,
  input logic             testedBit,
  input logic             nextIsTwoWord,
  input logic             resValid,
  input logic [PC_W-1:0]  nextPc,
  input logic             taken,
  input logic [1:0]       cycles
);

  function automatic logic [PC_W-1:0] relTarget(logic [PC_W-1:0] pc, logic [OFF_W-1:0] off);
    logic [PC_W-1:0] ext;
    ext = PC_W'($signed(off));
    return pc + PC_W'(1) + ext;
  endfunction

  always_comb begin
    if (!rstN) begin
      AST_RESET_IDLE: assert (!resValid && !taken && nextPc == '0 && cycles == 2'd0); // R1
    end
  end

  AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    evalValid |=> resValid); // R2

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !evalValid |=> (!resValid && $stable(nextPc) && $stable(taken) && $stable(cycles))); // R2

  AST_SIGN_FROM_NV: assert property (@(posedge clk) disable iff (!rstN)
    (evalValid && opMode == 2'b00 && flagIdx == 3'd4) |=>
      (taken == (($past(statusReg[2]) ^ $past(statusReg[3])) == $past(testSet)))); // R4

  AST_BRANCH_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    (evalValid && opMode == 2'b00) |=>
      (!taken || (cycles == 2'd2 && nextPc == relTarget($past(curPc), $past(offset))))); // R5

  AST_NOT_TAKEN_COST: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && !taken) |-> cycles == 2'd1); // R6

  AST_NOT_TAKEN_PC: assert property (@(posedge clk) disable iff (!rstN)
    evalValid |=> (taken || nextPc == $past(curPc) + PC_W'(1))); // R6

  AST_SKIP_EQUAL: assert property (@(posedge clk) disable iff (!rstN)
    (evalValid && opMode == 2'b01) |=> (taken == $past(regEqual))); // R7

  AST_SKIP_BIT: assert property (@(posedge clk) disable iff (!rstN)
    (evalValid && opMode == 2'b10) |=> (taken == ($past(testedBit) == $past(testSet)))); // R8

  AST_SKIP_LONG: assert property (@(posedge clk) disable iff (!rstN)
    (evalValid && opMode[1] != opMode[0] && nextIsTwoWord) |=>
      (!taken || (cycles == 2'd3 && nextPc == $past(curPc) + PC_W'(3)))); // R9

  AST_SKIP_SHORT: assert property (@(posedge clk) disable iff (!rstN)
    (evalValid && opMode[1] != opMode[0] && !nextIsTwoWord) |=>
      (!taken || (cycles == 2'd2 && nextPc == $past(curPc) + PC_W'(2)))); // R9

  AST_SEQ_NEVER: assert property (@(posedge clk) disable iff (!rstN)
    (evalValid && opMode == 2'b11) |=> !taken); // R10

endmodule

bind brskip_eval brskip_chk #(.PC_W(PC_W), .OFF_W(OFF_W)) uChk (
  .clk(clk), .rstN(rstN), .evalValid(evalValid), .opMode(opMode),
  .statusReg(statusReg), .flagIdx(flagIdx), .testSet(testSet), .offset(offset),
  .curPc(curPc), .regEqual(regEqual), .testedBit(testedBit),
  .nextIsTwoWord(nextIsTwoWord), .resValid(resValid), .nextPc(nextPc),
  .taken(taken), .cycles(cycles)
);

// File: tb/tb_brskip_eval.sv
`timescale 1ns/1ps
module tb_brskip_eval;

  localparam int PC_W = 16;
  localparam int OFF_W = 7;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic             rstN;
  logic             evalValid;
  logic [1:0]       opMode;
  logic [7:0]       statusReg;
  logic [2:0]       flagIdx;
  logic             testSet;
  logic [OFF_W-1:0] offset;
  logic [PC_W-1:0]  curPc;
  logic             regEqual;
  logic             testedBit;
  logic             nextIsTwoWord;
  logic             resValid;
  logic [PC_W-1:0]  nextPc;
  logic             taken;
  logic [1:0]       cycles;

  brskip_eval #(.PC_W(PC_W), .OFF_W(OFF_W)) dut (.*);

  int nChecks = 0;
  int nFails = 0;
  logic            expValid = 1'b0;
  logic [PC_W-1:0] expPc = '0;
  logic            expTaken = 1'b0;
  logic [1:0]      expCyc = '0;

  task automatic check(string tag);
    nChecks++;
    if (resValid !== expValid || nextPc !== expPc || taken !== expTaken || cycles !== expCyc) begin
      nFails++;
      $display("FAIL %s: got valid=%0b pc=%h taken=%0b cyc=%0d, expected valid=%0b pc=%h taken=%0b cyc=%0d",
               tag, resValid, nextPc, taken, cycles, expValid, expPc, expTaken, expCyc);
    end
  endtask

  // behavioural reference for one request
  task automatic model(input logic [1:0] md, input logic [7:0] sr, input logic [2:0] idx,
                       input logic ts, input logic [OFF_W-1:0] off, input logic [PC_W-1:0] pc,
                       input logic eq, input logic bt, input logic two);
    int  disp;
    int  bitVal;
    bit  tk;
    disp = off[OFF_W-1] ? int'(off) - (1 << OFF_W) : int'(off);
    case (md)
      2'b00: begin
        bitVal = (idx == 3'd4) ? int'(sr[2] ^ sr[3]) : int'(sr[idx]);
        tk = (bitVal == int'(ts));
      end
      2'b01: tk = eq;
      2'b10: tk = (bt == ts);
      default: tk = 1'b0;
    endcase
    expValid = 1'b1;
    expTaken = tk;
    if (!tk) begin
      expPc = PC_W'(int'(pc) + 1);
      expCyc = 2'd1;
    end else if (md == 2'b00) begin
      expPc = PC_W'(int'(pc) + 1 + disp);
      expCyc = 2'd2;
    end else begin
      expPc = PC_W'(int'(pc) + (two ? 3 : 2));
      expCyc = two ? 2'd3 : 2'd2;
    end
  endtask

  task automatic request(input logic [1:0] md, input logic [7:0] sr, input logic [2:0] idx,
                         input logic ts, input logic [OFF_W-1:0] off, input logic [PC_W-1:0] pc,
                         input logic eq, input logic bt, input logic two, input string tag);
    evalValid = 1'b1; opMode = md; statusReg = sr; flagIdx = idx; testSet = ts;
    offset = off; curPc = pc; regEqual = eq; testedBit = bt; nextIsTwoWord = two;
    model(md, sr, idx, ts, off, pc, eq, bt, two);
    @(negedge clk);
    check(tag);
  endtask

  task automatic idleCycle(input string tag);
    evalValid = 1'b0;
    opMode = 2'($urandom); statusReg = 8'($urandom); flagIdx = 3'($urandom);
    testSet = 1'($urandom); offset = OFF_W'($urandom); curPc = PC_W'($urandom);
    regEqual = 1'($urandom); testedBit = 1'($urandom); nextIsTwoWord = 1'($urandom);
    expValid = 1'b0;
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    #(200000 * 10);
    nFails++;
    $display("FAIL watchdog: got no end of run, expected finish before timeout");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    rstN = 1'b0; evalValid = 1'b0; opMode = 2'b00; statusReg = 8'h00; flagIdx = 3'd0;
    testSet = 1'b0; offset = '0; curPc = '0; regEqual = 1'b0; testedBit = 1'b0;
    nextIsTwoWord = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset state");
    evalValid = 1'b1; curPc = 16'h1234;
    @(negedge clk);
    check("R1 request ignored in reset");
    evalValid = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release");

    // R3: walk each raw flag with isolated and inverted patterns
    for (int i = 0; i < 8; i++) begin
      if (i == 4) continue;
      request(2'b00, 8'(1 << i), 3'(i), 1'b1, 7'd5, 16'h0100, 1'b0, 1'b0, 1'b0, "R3 set hit");
      request(2'b00, 8'(1 << i), 3'(i), 1'b0, 7'd5, 16'h0100, 1'b0, 1'b0, 1'b0, "R3 clear miss");
      request(2'b00, ~8'(1 << i), 3'(i), 1'b0, 7'd5, 16'h0100, 1'b0, 1'b0, 1'b0, "R3 clear hit");
      request(2'b00, ~8'(1 << i), 3'(i), 1'b1, 7'd5, 16'h0100, 1'b0, 1'b0, 1'b0, "R3 set miss");
    end

    // R4: index 4 follows N xor V, not the stored bit
    request(2'b00, 8'h10, 3'd4, 1'b1, 7'd3, 16'h0200, 1'b0, 1'b0, 1'b0, "R4 stored S only");
    request(2'b00, 8'h04, 3'd4, 1'b1, 7'd3, 16'h0200, 1'b0, 1'b0, 1'b0, "R4 N alone");
    request(2'b00, 8'h0C, 3'd4, 1'b0, 7'd3, 16'h0200, 1'b0, 1'b0, 1'b0, "R4 N and V");
    request(2'b00, 8'h18, 3'd4, 1'b0, 7'd3, 16'h0200, 1'b0, 1'b0, 1'b0, "R4 V with S");

    // R5: offset extremes and wrap
    request(2'b00, 8'h01, 3'd0, 1'b1, 7'h3F, 16'h1000, 1'b0, 1'b0, 1'b0, "R5 max forward");
    request(2'b00, 8'h01, 3'd0, 1'b1, 7'h40, 16'h1000, 1'b0, 1'b0, 1'b0, "R5 max backward");
    request(2'b00, 8'h01, 3'd0, 1'b1, 7'h7F, 16'h1000, 1'b0, 1'b0, 1'b0, "R5 minus one");
    request(2'b00, 8'h01, 3'd0, 1'b1, 7'h00, 16'hFFFF, 1'b0, 1'b0, 1'b0, "R5 wrap up");
    request(2'b00, 8'h01, 3'd0, 1'b1, 7'h40, 16'h0010, 1'b0, 1'b0, 1'b0, "R5 wrap down");

    // R6: not taken in each mode, including top address
    request(2'b00, 8'h00, 3'd1, 1'b1, 7'h20, 16'hFFFF, 1'b1, 1'b1, 1'b1, "R6 branch miss wrap");
    request(2'b01, 8'hFF, 3'd0, 1'b1, 7'h20, 16'h0300, 1'b0, 1'b1, 1'b1, "R6 equal miss");
    request(2'b10, 8'hFF, 3'd0, 1'b1, 7'h20, 16'h0300, 1'b1, 1'b0, 1'b1, "R6 bit miss");

    // R7: status and polarity do not matter
    request(2'b01, 8'h00, 3'd0, 1'b1, 7'h00, 16'h0400, 1'b1, 1'b0, 1'b0, "R7 equal hit");
    request(2'b01, 8'hFF, 3'd7, 1'b0, 7'h00, 16'h0400, 1'b1, 1'b1, 1'b0, "R7 equal hit other flags");
    request(2'b01, 8'hFF, 3'd7, 1'b1, 7'h00, 16'h0400, 1'b0, 1'b1, 1'b0, "R7 unequal");

    // R8: both polarities
    request(2'b10, 8'h00, 3'd0, 1'b1, 7'h00, 16'h0500, 1'b0, 1'b1, 1'b0, "R8 skip if set hit");
    request(2'b10, 8'h00, 3'd0, 1'b0, 7'h00, 16'h0500, 1'b0, 1'b0, 1'b0, "R8 skip if clear hit");
    request(2'b10, 8'h00, 3'd0, 1'b0, 7'h00, 16'h0500, 1'b0, 1'b1, 1'b0, "R8 skip if clear miss");

    // R9: short and long skips, with wrap
    request(2'b01, 8'h00, 3'd0, 1'b0, 7'h00, 16'h0600, 1'b1, 1'b0, 1'b0, "R9 short skip");
    request(2'b01, 8'h00, 3'd0, 1'b0, 7'h00, 16'h0600, 1'b1, 1'b0, 1'b1, "R9 long skip");
    request(2'b10, 8'h00, 3'd0, 1'b1, 7'h00, 16'hFFFE, 1'b0, 1'b1, 1'b1, "R9 long skip wrap");
    request(2'b10, 8'h00, 3'd0, 1'b1, 7'h00, 16'hFFFF, 1'b0, 1'b1, 1'b0, "R9 short skip wrap");

    // R10: sequential mode with every condition pointing at taken
    request(2'b11, 8'hFF, 3'd0, 1'b1, 7'h10, 16'h0700, 1'b1, 1'b1, 1'b1, "R10 sequential");

    // R11: offset ignored on skips, length hint ignored on branches
    request(2'b01, 8'h00, 3'd0, 1'b0, 7'h55, 16'h0800, 1'b1, 1'b0, 1'b0, "R11 skip with offset");
    request(2'b00, 8'h02, 3'd1, 1'b1, 7'h05, 16'h0800, 1'b0, 1'b0, 1'b1, "R11 branch with long hint");

    // R2: holds across idle clocks, then back-to-back requests
    idleCycle("R2 idle hold");
    idleCycle("R2 idle hold second");
    request(2'b00, 8'h80, 3'd7, 1'b1, 7'h02, 16'h0900, 1'b0, 1'b0, 1'b0, "R2 back to back first");
    request(2'b00, 8'h80, 3'd7, 1'b0, 7'h02, 16'h0A00, 1'b0, 1'b0, 1'b0, "R2 back to back second");
    idleCycle("R2 idle after burst");

    // mixed traffic against the reference model
    for (int n = 0; n < 3000; n++) begin
      if (($urandom % 5) == 0) begin
        idleCycle("R2 random idle");
      end else begin
        logic [1:0] md;
        md = 2'($urandom);
        request(md, 8'($urandom), 3'($urandom), 1'($urandom), OFF_W'($urandom),
                PC_W'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                md == 2'b00 ? "R3 R4 R5 R6 random branch" :
                md == 2'b01 ? "R7 R9 random equal skip" :
                md == 2'b10 ? "R8 R9 random bit skip" : "R10 random sequential");
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule